// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host access to a second register space through three host-side registers. The first is a command register, which holds a target address and an operation code. The second is a write-data register. The third is a read-data register that also carries the completion state. When the host writes the command register while the bridge is idle, the bridge starts exactly one transaction on a level-held request/acknowledge port toward the second space. The bridge keeps the request asserted until the far side acknowledges it or until a fixed cycle limit runs out.

The result is reported in the upper bits of the read-data register. Those bits hold a ready flag and a two-bit outcome code. For a successful read, the read-data register also carries the returned value in its low half. Host software starts an operation by writing the command register, then polls the read-data register until the ready flag is set.

The three host registers are selected with `host_sel`:
- 0 selects the command register.
- 1 selects the write-data register.
- 2 selects the read-data register.
- 3 reads as zero.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, the command, write-data and read-data registers all read as zero, and `sec_req` is low.
- R2: The command word carries the address in bits [15:0] and the operation code in bits [17:16]. Reading the command register returns the last command that was accepted. A command with code 1 (write), written while idle, raises `sec_req` on the next cycle with `sec_we`=1, the command's address, and the write-data register value. The same write clears the read-data register.
- R3: A command with code 2 (read) raises `sec_req` with `sec_we`=0. On an acknowledge without error, the read-data register becomes ready (bit 18 = 1), outcome 01 (bits [17:16]), with `sec_rdata` in bits [15:0].
- R4: An acknowledge with `sec_err`=1 completes the transaction with outcome 11 and a data field of zero, for both reads and writes.
- R5: If no acknowledge arrives, `sec_req` is held for exactly 32 cycles. The bridge then drops it and reports ready with outcome 00. An acknowledge in the 32nd cycle still counts as a response.
- R6: A command with code 0 or 3 starts no request. It completes on the same edge with ready set and outcome 10.
- R7: A command written while a transaction is in flight is ignored. The address and direction on the port do not change, and the command register keeps its earlier value.
- R8: While a request is pending, `sec_addr`, `sec_we` and `sec_wdata` stay stable. `sec_req` drops on the edge that completes the transaction.
- R9: A write to the write-data register during a transaction updates the register but does not change `sec_wdata` for the transaction in flight.
- R10: An acknowledge that arrives while no request is pending has no effect.
- R11: Host writes to the read-data register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the selected register |
| host_sel | input | 2 | Register select: 0 command, 1 write data, 2 read data |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Selected register value (combinational) |
| sec_req | output | 1 | Request toward the secondary space, held until completion |
| sec_we | output | 1 | 1 = write, 0 = read |
| sec_addr | output | 16 | Target address |
| sec_wdata | output | 16 | Data for a write |
| sec_ack | input | 1 | Response from the secondary space |
| sec_err | input | 1 | Response carries an error (valid with `sec_ack`) |
| sec_rdata | input | 16 | Read value (valid with `sec_ack`) |

## Verification
The hardest situations to reach from the ports are host activity during an open transaction and the acknowledge that arrives in the final permitted cycle. The first is a new command or new write data landing while a request is still pending. The second makes the acknowledge race against the timeout. The bench's responder model takes a programmable acknowledge delay, so the request can be held open for several cycles. During that window the bench rewrites the write-data and command registers and checks that the port does not move. Two further runs cover the limit: one sets the delay so the acknowledge arrives in cycle 32, and one switches the responder off and counts the cycles until ready.

// File: rtl/ibr_pkg.sv
// Package: shared encodings for the indirect register access bridge.
// Assumes: operation and outcome codes are two bits wide.
package ibr_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RSVD  = 2'd3
    } ibr_op_e;

    typedef enum logic [1:0] {
        ST_NORESP  = 2'd0,
        ST_OK      = 2'd1,
        ST_REQFAIL = 2'd2,
        ST_RESPERR = 2'd3
    } ibr_st_e;

    localparam logic [1:0] SEL_CMD   = 2'd0;
    localparam logic [1:0] SEL_WDATA = 2'd1;
    localparam logic [1:0] SEL_RDATA = 2'd2;
endpackage

// File: rtl/ibr_watchdog_cnt.sv
// Module: counts the cycles a request stays pending and flags the last one.
// Assumes: run stays high for a whole transaction; the counter restarts when run is low.
module ibr_watchdog_cnt #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    // Count pending cycles; restart while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // Final permitted cycle of a pending request.
    assign expire = run && (cnt == CW'(LIMIT - 1));

    // R5
    tmo_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
endmodule

// File: rtl/ibr_engine.sv
// Module: runs one secondary-port transaction per accepted command and
// produces the completion pulse with outcome and data.
// Assumes: the responder holds sec_ack for one cycle; ack wins over timeout.
module ibr_engine
    import ibr_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int TIMEOUT = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    start_op,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    output logic          sec_req,
    output logic          sec_we,
    output logic [AW-1:0] sec_addr,
    output logic [DW-1:0] sec_wdata,
    input  logic          sec_ack,
    input  logic          sec_err,
    input  logic [DW-1:0] sec_rdata,
    output logic          busy,
    output logic          done,
    output logic [1:0]    done_status,
    output logic [DW-1:0] done_data
);
    logic          busy_q;
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          tmo;
    logic          op_ok;
    logic          launch;
    logic          reject;
    logic          finish;

    assign op_ok  = (start_op == OP_WRITE) || (start_op == OP_READ);
    assign launch = start && !busy_q && op_ok;
    assign reject = start && !busy_q && !op_ok;
    assign finish = busy_q && (sec_ack || tmo);

    ibr_watchdog_cnt #(.LIMIT(TIMEOUT)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy_q),
        .expire (tmo)
    );

    // Pending flag: set on launch, cleared on response or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (finish) busy_q <= 1'b0;
        else if (launch) busy_q <= 1'b1;
    end

    // Capture the transaction fields so later host writes cannot disturb them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (launch) begin
            we_q    <= (start_op == OP_WRITE);
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
        end
    end

    // Completion outcome and returned data.
    always_comb begin
        done_status = ST_NORESP;
        done_data   = '0;
        if (reject) begin
            done_status = ST_REQFAIL;
        end else if (busy_q && sec_ack) begin
            done_status = sec_err ? ST_RESPERR : ST_OK;
            if (!we_q && !sec_err) done_data = sec_rdata;
        end
    end

    assign done      = finish || reject;
    assign busy      = busy_q;
    assign sec_req   = busy_q;
    assign sec_we    = we_q;
    assign sec_addr  = addr_q;
    assign sec_wdata = wdata_q;

    // R2
    launch_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q && start_op == OP_WRITE)
        |=> (sec_req && sec_we && sec_addr == $past(start_addr)));

    // R6
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q && (start_op == OP_NONE || start_op == OP_RSVD)) |=> !sec_req);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !sec_ack && !tmo)
        |=> (sec_req && $stable(sec_addr) && $stable(sec_we) && $stable(sec_wdata)));

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy_q) |=> ($stable(sec_addr) && $stable(sec_we)));

    // R10
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start && sec_ack) |-> !done);
endmodule

// File: rtl/ind_reg_bridge.sv
// Module: host register window (command, write data, read data/status) in
// front of the transaction engine.
// Assumes: single host access per cycle; host_rdata is a combinational read
// with no side effects.
module ind_reg_bridge
    import ibr_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int TIMEOUT = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [1:0]    host_sel,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    output logic          sec_req,
    output logic          sec_we,
    output logic [AW-1:0] sec_addr,
    output logic [DW-1:0] sec_wdata,
    input  logic          sec_ack,
    input  logic          sec_err,
    input  logic [DW-1:0] sec_rdata
);
    localparam int CMDW = AW + 2;
    localparam int RDW  = DW + 3;
    localparam int RDY  = DW + 2;

    logic [CMDW-1:0] cmd_q;
    logic [DW-1:0]   wdata_q;
    logic [RDW-1:0]  rd_q;
    logic            cmd_wr;
    logic            busy;
    logic            done;
    logic [1:0]      done_status;
    logic [DW-1:0]   done_data;
    logic            unused_hi;

    assign cmd_wr    = host_wr && (host_sel == SEL_CMD);
    assign unused_hi = ^host_wdata[31:CMDW];

    ibr_engine #(.AW(AW), .DW(DW), .TIMEOUT(TIMEOUT)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cmd_wr),
        .start_op    (host_wdata[CMDW-1:AW]),
        .start_addr  (host_wdata[AW-1:0]),
        .start_wdata (wdata_q),
        .sec_req     (sec_req),
        .sec_we      (sec_we),
        .sec_addr    (sec_addr),
        .sec_wdata   (sec_wdata),
        .sec_ack     (sec_ack),
        .sec_err     (sec_err),
        .sec_rdata   (sec_rdata),
        .busy        (busy),
        .done        (done),
        .done_status (done_status),
        .done_data   (done_data)
    );

    // Command register: only accepted while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                cmd_q <= '0;
        else if (cmd_wr && !busy)  cmd_q <= host_wdata[CMDW-1:0];
    end

    // Write-data register: always writable by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  wdata_q <= '0;
        else if (host_wr && host_sel == SEL_WDATA)   wdata_q <= host_wdata[DW-1:0];
    end

    // Read-data register: result on completion, cleared when a command starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                rd_q <= '0;
        else if (done)             rd_q <= {1'b1, done_status, done_data};
        else if (cmd_wr && !busy)  rd_q <= '0;
    end

    // Host read mux.
    always_comb begin
        host_rdata = '0;
        case (host_sel)
            SEL_CMD:   host_rdata[CMDW-1:0] = cmd_q;
            SEL_WDATA: host_rdata[DW-1:0]   = wdata_q;
            SEL_RDATA: host_rdata[RDW-1:0]  = rd_q;
            default:   host_rdata = '0;
        endcase
    end

    // R8
    drop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sec_req) |-> rd_q[RDY]);

    // R3
    pending_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_req |-> !rd_q[RDY]);
endmodule

// File: tb/ind_reg_bridge_tb.sv
module ind_reg_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd2;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        sec_req, sec_we;
    logic [15:0] sec_addr, sec_wdata;
    logic        sec_ack = 1'b0;
    logic        sec_err = 1'b0;
    logic [15:0] sec_rdata = '0;

    int total = 0;
    int bad = 0;

    // responder controls
    bit rsp_on = 1'b1;
    bit rsp_err = 1'b0;
    int rsp_delay = 0;
    int wait_n = 0;
    bit stray = 1'b0;
    bit req_seen = 1'b0;

    // scoreboard
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          pending = 1'b0;

    always #2 clk = ~clk;

    ind_reg_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sec_req(sec_req), .sec_we(sec_we), .sec_addr(sec_addr), .sec_wdata(sec_wdata),
        .sec_ack(sec_ack), .sec_err(sec_err), .sec_rdata(sec_rdata)
    );

    // Responder model: acknowledges after rsp_delay pending cycles.
    always @(negedge clk) begin
        if (sec_req) req_seen = 1'b1;
        if (sec_req && rsp_on && wait_n == rsp_delay) begin
            sec_ack   = 1'b1;
            sec_err   = rsp_err;
            sec_rdata = sec_we ? 16'h0 : (sec_addr ^ 16'h5A3C);
        end else begin
            sec_ack   = stray;
            sec_err   = 1'b0;
            sec_rdata = 16'h0;
        end
        if (sec_req) wait_n = wait_n + 1;
        else         wait_n = 0;
    end

    // Monitor: pops the expected read-data word once ready is seen.
    always @(negedge clk) begin
        if (pending && host_sel == 2'd2 && host_rdata[18]) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (host_rdata !== e) begin
                bad++;
                $display("FAIL %s: rdata got=%h exp=%h", t, host_rdata, e);
            end
            pending = 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [31:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0; host_sel = 2'd2;
    endtask

    task automatic read_sel(input logic [1:0] sel, output logic [31:0] v);
        @(posedge clk); #1;
        host_sel = sel;
        @(negedge clk);
        v = host_rdata;
        host_sel = 2'd2;
    endtask

    // Driver: issue a command and push its expected result.
    task automatic issue(input string tag, input logic [1:0] op, input logic [15:0] addr,
                         input logic [31:0] exp);
        host_write(2'd0, {14'b0, op, addr});
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        pending = 1'b1;
    endtask

    task automatic wait_done;
        while (pending) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        read_sel(2'd0, v); check("R1 cmd", v, 32'h0);
        read_sel(2'd1, v); check("R1 wdata", v, 32'h0);
        read_sel(2'd2, v); check("R1 rdata", v, 32'h0);
        check("R1 req", {31'b0, sec_req}, 32'h0);

        // R2 write transaction, with R9 and R7 during it
        host_write(2'd1, 32'h0000BEEF);
        rsp_delay = 8; rsp_err = 0;
        issue("R2 write ok", 2'd1, 16'h1234, 32'h00050000);
        @(negedge clk);
        check("R2 req", {31'b0, sec_req}, 32'h1);
        check("R2 we", {31'b0, sec_we}, 32'h1);
        check("R2 addr", {16'b0, sec_addr}, 32'h1234);
        check("R2 wdata", {16'b0, sec_wdata}, 32'hBEEF);
        host_write(2'd1, 32'h00001111);
        @(negedge clk);
        check("R9 wdata latched", {16'b0, sec_wdata}, 32'hBEEF);
        host_write(2'd0, 32'h00020777);
        @(negedge clk);
        check("R7 addr kept", {16'b0, sec_addr}, 32'h1234);
        check("R7 we kept", {31'b0, sec_we}, 32'h1);
        wait_done();
        check("R8 req dropped", {31'b0, sec_req}, 32'h0);
        read_sel(2'd0, v); check("R7 cmd reg kept", v, 32'h00011234);
        read_sel(2'd1, v); check("R9 wdata reg updated", v, 32'h1111);

        // R3 read ok
        rsp_delay = 0;
        issue("R3 read ok", 2'd2, 16'h00F0, 32'h00050000 | (32'h00F0 ^ 32'h5A3C));
        @(negedge clk);
        check("R3 we", {31'b0, sec_we}, 32'h0);
        wait_done();
        rsp_delay = 5;
        issue("R3 read ok 2", 2'd2, 16'hFFFF, 32'h00050000 | (32'hFFFF ^ 32'h5A3C));
        wait_done();

        // R4 error responses
        rsp_delay = 3; rsp_err = 1;
        issue("R4 read err", 2'd2, 16'h0042, 32'h00070000);
        wait_done();
        issue("R4 write err", 2'd1, 16'h0043, 32'h00070000);
        wait_done();
        rsp_err = 0;

        // R5 timeout and its boundary
        rsp_on = 0;
        issue("R5 timeout", 2'd2, 16'h0100, 32'h00040000);
        n = 0;
        do begin @(negedge clk); n++; end while (!host_rdata[18]);
        check("R5 timeout latency", n, 33);
        check("R5 req dropped", {31'b0, sec_req}, 32'h0);
        wait_done();
        rsp_on = 1; rsp_delay = 31;
        issue("R5 ack last cycle", 2'd2, 16'h0200, 32'h00050000 | (32'h0200 ^ 32'h5A3C));
        wait_done();

        // R6 reserved codes
        @(negedge clk); req_seen = 0;
        issue("R6 code0", 2'd0, 16'h0300, 32'h00060000);
        wait_done();
        issue("R6 code3", 2'd3, 16'h0301, 32'h00060000);
        wait_done();
        repeat (2) @(negedge clk);
        check("R6 no request", {31'b0, req_seen}, 32'h0);

        // R10 stray acknowledge while idle
        @(posedge clk); #1 stray = 1;
        repeat (3) @(posedge clk);
        #1 stray = 0;
        read_sel(2'd2, v); check("R10 rdata unchanged", v, 32'h00060000);
        check("R10 req low", {31'b0, req_seen}, 32'h0);

        // R11 host write to read-data register
        host_write(2'd2, 32'h0000ABCD);
        read_sel(2'd2, v); check("R11 rdata unchanged", v, 32'h00060000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule